// File: doc/BRIEF.md
# Single/Double Float Load-Store Converter

This block reformats floating-point data as it moves between memory and a
register file that keeps every value in binary64 form. On the load side, a
32-bit binary32 memory word is widened into the 64-bit register image. On the
store side, a 64-bit register value is narrowed into the 32-bit word written to
memory. Neither direction does arithmetic: bits are moved, exponents are
rebiased by routing, and nothing is rounded, quieted or flagged. The same
conversions apply to every bit pattern, including infinities and NaNs.

The one place where real work is done is the subnormal range. A subnormal
binary32 word is normalised on load: its leading one is found, the exponent is
derived from that position, and the remaining bits become the fraction. On
store, a value whose exponent lies in a fixed window just below the binary32
normal range is shifted back into a subnormal word, with the low bits simply
cut off. Values below that window become a zero that keeps the sign. Each
direction has its own valid strobe, and each result is registered with one
cycle of latency.

Top module: `fls_conv`

## Requirements
- R1: While `rstN` is low, `ldOutValid` and `stOutValid` are 0, and `ldResult` and `stResult` are all zeros.
- R2: `ldOutValid` (and `stOutValid`) is 1 in the cycle after an edge where `ldValid` (and `stValid`) was 1, and 0 otherwise; the matching result is present in that same cycle.
- R3: After an edge where a side's valid input was 0, that side's result output keeps its previous value, whatever the data input held.
- R4: Load, magnitude `ldWord[30:0]` at least 0x00800000: `ldResult[63:62]` = `ldWord[31:30]`, `ldResult[61:59]` = three copies of the inverse of `ldWord[30]`, `ldResult[58:29]` = `ldWord[29:0]`, and `ldResult[28:0]` = 0. Numerically the exponent field equals the binary32 exponent plus 896.
- R5: Load, magnitude 0: `ldResult[63]` = `ldWord[31]` and all other bits are 0.
- R6: Load, magnitude from 1 to 0x007FFFFF with its highest set bit at position p: sign kept, exponent field `ldResult[62:52]` = 874 + p (that is 896 minus the shift, the shift being the magnitude's leading-zero count within 32 bits less 9), and `ldResult[51:0]` holds the magnitude bits below p, left-aligned, so the value is unchanged.
- R7: Store, exponent field `stValue[62:52]` above 896: `stResult[31:30]` = `stValue[63:62]` and `stResult[29:0]` = `stValue[58:29]`.
- R8: Store, exponent field from 874 to 896 inclusive: `stResult[31]` = `stValue[63]` and `stResult[30:0]` = the 53-bit significand (a one above `stValue[51:0]`) shifted right by 926 minus the exponent, with the shifted-out bits dropped.
- R9: Store, exponent field below 874: `stResult[31]` = `stValue[63]` and `stResult[30:0]` = 0.
- R10: Storing the result of a load gives back the original 32-bit word, for normal, subnormal, zero, infinity and NaN words of either sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| ldValid | input | 1 | Load word present this cycle |
| ldWord | input | 32 | binary32 word read from memory |
| stValid | input | 1 | Store value present this cycle |
| stValue | input | 64 | binary64 register image to be stored |
| ldOutValid | output | 1 | `ldResult` holds a fresh conversion |
| ldResult | output | 64 | Widened register image |
| stOutValid | output | 1 | `stResult` holds a fresh conversion |
| stResult | output | 32 | Narrowed memory word |

## Verification
The bench sweeps every binary32 exponent code with both signs and a spread of mantissas, then every subnormal leading-one position, and every one of the 2048 binary64 exponent codes on the store side. A leading-zero count that is off by one would give a subnormal load the wrong exponent and a fraction that still carries its leading one; an inverted rebias bit would send exponents 1 to 127 to the wrong half of the range. The store window edges 873, 874, 896 and 897 are all hit, so a shift base that is wrong by one, or a window test using the wrong comparison, shows up as a halved or doubled subnormal, or as a flushed value that should have survived. Each load is also fed back through the store path, which catches any pair of mismatched routings.

// File: rtl/fls_pkg.sv
package fls_pkg;
  // Format widths
  localparam int SP_W      = 32;
  localparam int DP_W      = 64;
  localparam int SP_EXP_W  = 8;
  localparam int DP_EXP_W  = 11;
  localparam int SP_FRAC_W = 23;
  localparam int DP_FRAC_W = 52;

  // Derived constants
  localparam int FRAC_GAP     = DP_FRAC_W - SP_FRAC_W;          // 29
  localparam int TOP_FILL     = DP_EXP_W - SP_EXP_W;            // 3
  localparam int LZ_BIAS      = SP_W - SP_FRAC_W;               // 9
  localparam int SP_BIAS      = (1 << (SP_EXP_W - 1)) - 1;      // 127
  localparam int DP_BIAS      = (1 << (DP_EXP_W - 1)) - 1;      // 1023
  localparam int BIAS_GAP     = DP_BIAS - SP_BIAS;              // 896
  localparam int DENORM_FLOOR = BIAS_GAP - (SP_FRAC_W - 1);     // 874
  localparam int SHIFT_BASE   = BIAS_GAP + FRAC_GAP + 1;        // 926
  localparam int MIN_NORMAL   = 1 << SP_FRAC_W;                 // 0x00800000

  // Strobes from control to datapath
  typedef struct packed {
    logic ldCapture;
    logic stCapture;
  } fls_strobe_t;
endpackage

// File: rtl/fls_lzc.sv
module fls_lzc #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  value,
  output logic [CW-1:0] count
);
  always_comb begin
    count = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (value[i]) count = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fls_ctrl.sv
module fls_ctrl
  import fls_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldValid,
  input  logic        stValid,
  output fls_strobe_t strobe,
  output logic        ldOutValid,
  output logic        stOutValid
);
  always_comb begin
    strobe.ldCapture = ldValid;
    strobe.stCapture = stValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldOutValid <= 1'b0;
      stOutValid <= 1'b0;
    end else begin
      ldOutValid <= ldValid;
      stOutValid <= stValid;
    end
  end
endmodule

// File: rtl/fls_datapath.sv
module fls_datapath
  import fls_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  fls_strobe_t     strobe,
  input  logic [SP_W-1:0] ldWord,
  input  logic [DP_W-1:0] stValue,
  output logic [DP_W-1:0] ldResult,
  output logic [SP_W-1:0] stResult
);
  localparam int MAG_W = SP_W - 1;
  localparam int CNT_W = $clog2(SP_W + 1);
  localparam int SH_W  = $clog2(DP_W);

  // ---------------- load: binary32 -> binary64 ----------------
  logic [MAG_W-1:0]     ldMag;
  logic                 ldIsNormal;
  logic [CNT_W-1:0]     lzCount;
  logic [SH_W-1:0]      denShift;
  logic [SH_W-1:0]      normShift;
  logic [DP_EXP_W-1:0]  denExp;
  logic [DP_FRAC_W-1:0] denFrac;
  logic [DP_W-1:0]      ldNext;

  assign ldMag      = ldWord[MAG_W-1:0];
  assign ldIsNormal = ldMag >= MAG_W'(MIN_NORMAL);

  fls_lzc #(.W(SP_W)) u_lzc (
    .value ({1'b0, ldMag}),
    .count (lzCount)
  );

  // Distance of the leading one below the top of the binary32 fraction
  assign denShift  = SH_W'(lzCount) - SH_W'(LZ_BIAS);
  // Shift that parks the leading one just above the 52-bit fraction
  assign normShift = denShift + SH_W'(FRAC_GAP + 1);
  assign denExp    = DP_EXP_W'(BIAS_GAP) - DP_EXP_W'(denShift);
  assign denFrac   = DP_FRAC_W'(ldMag) << normShift;

  always_comb begin
    if (ldIsNormal) begin
      ldNext = {ldWord[SP_W-1 -: 2],
                {TOP_FILL{~ldWord[SP_W-2]}},
                ldWord[SP_W-3:0],
                {FRAC_GAP{1'b0}}};
    end else if (ldMag == '0) begin
      ldNext = {ldWord[SP_W-1], {(DP_W-1){1'b0}}};
    end else begin
      ldNext = {ldWord[SP_W-1], denExp, denFrac};
    end
  end

  // ---------------- store: binary64 -> binary32 ----------------
  logic [DP_EXP_W-1:0]  stExp;
  logic [DP_FRAC_W:0]   stSig;
  logic [DP_EXP_W-1:0]  stRsh;
  logic [SP_W-2:0]      stDen;
  logic [SP_W-1:0]      stNext;

  assign stExp = stValue[DP_W-2 -: DP_EXP_W];
  assign stSig = {1'b1, stValue[DP_FRAC_W-1:0]};
  assign stRsh = DP_EXP_W'(SHIFT_BASE) - stExp;
  assign stDen = (SP_W-1)'(stSig >> stRsh);

  always_comb begin
    if (stExp > DP_EXP_W'(BIAS_GAP)) begin
      stNext = {stValue[DP_W-1 -: 2], stValue[DP_W-3-TOP_FILL -: SP_W-2]};
    end else if (stExp >= DP_EXP_W'(DENORM_FLOOR)) begin
      stNext = {stValue[DP_W-1], stDen};
    end else begin
      stNext = {stValue[DP_W-1], {(SP_W-1){1'b0}}};
    end
  end

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldResult <= '0;
      stResult <= '0;
    end else begin
      if (strobe.ldCapture) ldResult <= ldNext;
      if (strobe.stCapture) stResult <= stNext;
    end
  end
endmodule

// File: rtl/fls_conv.sv
module fls_conv
  import fls_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            ldValid,
  input  logic [SP_W-1:0] ldWord,
  input  logic            stValid,
  input  logic [DP_W-1:0] stValue,
  output logic            ldOutValid,
  output logic [DP_W-1:0] ldResult,
  output logic            stOutValid,
  output logic [SP_W-1:0] stResult
);
  fls_strobe_t strobe;

  fls_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ldValid    (ldValid),
    .stValid    (stValid),
    .strobe     (strobe),
    .ldOutValid (ldOutValid),
    .stOutValid (stOutValid)
  );

  fls_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .ldWord   (ldWord),
    .stValue  (stValue),
    .ldResult (ldResult),
    .stResult (stResult)
  );
endmodule

// File: rtl/fls_conv_chk.sv
module fls_conv_chk
  import fls_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            ldValid,
  input logic [SP_W-1:0] ldWord,
  input logic            stValid,
  input logic [DP_W-1:0] stValue,
  input logic            ldOutValid,
  input logic [DP_W-1:0] ldResult,
  input logic            stOutValid,
  input logic [SP_W-1:0] stResult
);
  // R2
  ld_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |=> ldOutValid);
  // R2
  ld_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |=> !ldOutValid);
  // R2
  st_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    stValid |=> stOutValid);
  // R3
  ld_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ldValid |=> $stable(ldResult));
  // R3
  st_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stValid |=> $stable(stResult));
  // R4
  ld_norm_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldWord[SP_W-2:SP_FRAC_W] != '0) |=> ldResult[FRAC_GAP-1:0] == '0);
  // R5
  ld_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldValid && ldWord[SP_W-2:0] == '0) |=> ldResult[DP_W-2:0] == '0);
  // R9
  st_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stValue[DP_W-2 -: DP_EXP_W] < DP_EXP_W'(DENORM_FLOOR))
      |=> stResult[SP_W-2:0] == '0);
endmodule

bind fls_conv fls_conv_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .ldValid    (ldValid),
  .ldWord     (ldWord),
  .stValid    (stValid),
  .stValue    (stValue),
  .ldOutValid (ldOutValid),
  .ldResult   (ldResult),
  .stOutValid (stOutValid),
  .stResult   (stResult)
);

// File: tb/fls_conv_tb.sv
module fls_conv_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        ldValid;
  logic [31:0] ldWord;
  logic        stValid;
  logic [63:0] stValue;
  logic        ldOutValid;
  logic [63:0] ldResult;
  logic        stOutValid;
  logic [31:0] stResult;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fls_conv u_dut (
    .clk(clk), .rstN(rstN),
    .ldValid(ldValid), .ldWord(ldWord),
    .stValid(stValid), .stValue(stValue),
    .ldOutValid(ldOutValid), .ldResult(ldResult),
    .stOutValid(stOutValid), .stResult(stResult)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected widening, computed from the value
  function automatic logic [63:0] expLoad(input logic [31:0] w);
    logic [7:0]  e8 = w[30:23];
    logic [22:0] m  = w[22:0];
    logic [63:0] frac;
    int p;
    if (e8 != 0) return {w[31], 11'(e8) + 11'd896, m, 29'b0};
    if (m == 0)  return {w[31], 63'b0};
    p = 0;
    for (int i = 0; i < 23; i++) if (m[i]) p = i;
    frac = (64'(m) - (64'd1 << p)) << (52 - p);
    return {w[31], 11'(874 + p), frac[51:0]};
  endfunction

  // Expected narrowing, from the bit positions and window of R7..R9
  function automatic logic [31:0] expStore(input logic [63:0] v);
    int e = int'(v[62:52]);
    logic [63:0] sig;
    if (e > 896) return {v[63:62], v[58:29]};
    if (e >= 874) begin
      sig = (64'd1 << 52) | 64'(v[51:0]);
      sig = sig >> (926 - e);
      return {v[63], sig[30:0]};
    end
    return {v[63], 31'b0};
  endfunction

  function automatic string loadTag(input logic [31:0] w);
    if (w[30:23] != 0) return "R4";
    if (w[22:0] == 0)  return "R5";
    return "R6";
  endfunction

  function automatic string storeTag(input logic [63:0] v);
    if (v[62:52] > 11'd896)  return "R7";
    if (v[62:52] >= 11'd874) return "R8";
    return "R9";
  endfunction

  task automatic doLoad(input logic [31:0] w);
    ldValid = 1'b1; ldWord = w; stValid = 1'b0;
    @(negedge clk);
    check("R2 ldOutValid", 64'(ldOutValid), 64'd1);
    check(loadTag(w), ldResult, expLoad(w));
  endtask

  task automatic doStore(input logic [63:0] v);
    stValid = 1'b1; stValue = v; ldValid = 1'b0;
    @(negedge clk);
    check("R2 stOutValid", 64'(stOutValid), 64'd1);
    check(storeTag(v), 64'(stResult), 64'(expStore(v)));
  endtask

  task automatic roundTrip(input logic [31:0] w);
    logic [63:0] wide;
    doLoad(w);
    wide = ldResult;
    doStore(wide);
    check("R10 round trip", 64'(stResult), 64'(w));
  endtask

  initial begin
    logic [63:0] heldLd;
    logic [31:0] heldSt;
    rstN = 1'b0; ldValid = 1'b0; stValid = 1'b0; ldWord = '1; stValue = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 ldOutValid", 64'(ldOutValid), 64'd0);
    check("R1 stOutValid", 64'(stOutValid), 64'd0);
    check("R1 ldResult", ldResult, 64'd0);
    check("R1 stResult", 64'(stResult), 64'd0);
    rstN = 1'b1;
    ldWord = '0; stValue = '0;
    @(negedge clk);
    check("R2 idle ld", 64'(ldOutValid), 64'd0);

    // R4/R5/R6/R10: every exponent code, both signs, a spread of mantissas
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 256; e++)
        for (int k = 0; k < 16; k++) begin
          logic [22:0] m;
          m = (k == 0) ? 23'd0 : (k == 1) ? 23'h7FFFFF : (k == 2) ? 23'd1 :
              23'((k * 32'h0005A3C7) ^ (k << 19));
          roundTrip({1'(s), 8'(e), m});
        end

    // R6/R10: every leading-one position of a subnormal
    for (int s = 0; s < 2; s++)
      for (int p = 0; p < 23; p++)
        for (int k = 0; k < 8; k++) begin
          logic [22:0] m;
          m = 23'((32'd1 << p) | ((k * 32'h002AAAAB) & ((32'd1 << p) - 1)));
          roundTrip({1'(s), 8'd0, m});
        end

    // R7/R8/R9: every binary64 exponent code
    for (int s = 0; s < 2; s++)
      for (int e = 0; e < 2048; e++)
        for (int k = 0; k < 4; k++) begin
          logic [51:0] f;
          f = (k == 0) ? 52'd0 : (k == 1) ? '1 : (k == 2) ? 52'h8_0000_0000_0001
                                                          : 52'h5_5555_5555_5555;
          doStore({1'(s), 11'(e), f});
        end

    // R3: results hold while valids are low
    doLoad(32'h3F80_0001);
    doStore(64'h4000_0000_2000_0000);
    heldLd = ldResult;
    heldSt = stResult;
    ldValid = 1'b0; stValid = 1'b0;
    ldWord = 32'h8000_0001; stValue = 64'h0000_0000_0000_0000;
    @(negedge clk);
    check("R3 ldOutValid low", 64'(ldOutValid), 64'd0);
    check("R3 stOutValid low", 64'(stOutValid), 64'd0);
    check("R3 ldResult held", ldResult, heldLd);
    check("R3 stResult held", 64'(stResult), 64'(heldSt));
    @(negedge clk);
    check("R3 ldResult still held", ldResult, heldLd);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R2 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule